// File: doc/BRIEF.md
# Indexed Codec Control Register Interface

This block is the host-facing control port of an audio codec. The host sees four direct byte locations: an index pointer, a data window onto an indirect register file, a status byte and a programmed-I/O data byte. The index pointer chooses one of 32 indirect registers. A mode bit decides whether the pointer's low four bits or its low five bits form that choice, so the upper half of the file is reachable only in the extended mode. The block applies the codec's write rules to each indirect register. Format changes are gated. Some registers are read-only or reserved. In the mode register only one bit is writable.

The stored playback format byte is decoded continuously into a crystal select, a rate index, a stereo flag, a sample-format code and an error flag. The interface-configuration register turns a DMA request level on and off. That level also drops whenever a newly accepted format is unusable. A playback-done event input raises the interrupt line and a pending flag. The host clears them either by writing the status location or by clearing the pending bit in the alternate status register.

Register layout, by decimal index: 8 playback format, 9 interface configuration (bit 0 playback enable, bit 5 reserved, bit 6 programmed-I/O select), 11 error status, 12 mode (bit 6 extended mode), 18/20/28 reserved, 24 alternate status (bit 3 partial format change enable, bit 4 playback pending, bit 5 capture pending, bit 6 timer pending). Bit 6 of the index pointer is the format change enable. Direct locations: 0 index, 1 data, 2 status (bit 0 interrupt flag), 3 programmed-I/O data (reads zero, writes ignored).

Top module: `codec_idx_regs`

## Requirements
- R1: A write to direct location 0 stores the byte with bit 7 forced to zero, and reading location 0 returns the stored value.
- R2: With the extended mode bit (register 12, bit 6) clear, the indirect index is the pointer's low 4 bits. With it set, the index is the low 5 bits.
- R3: With pointer bit 6 set, a write to register 8 replaces the whole byte.
- R4: With pointer bit 6 clear and register 24 bit 3 set, a write to register 8 takes bits 7:4 from the written byte and keeps the old bits 3:0.
- R5: With both change enables clear, a write to register 8 leaves it unchanged.
- R6: The format outputs are: crystal = bit 0, rate = bits 3:1, stereo = bit 4, code = bits 7:5. The code is masked to bits 6:5 when extended mode is clear. The codes are 0 unsigned 8-bit, 1 mu-law, 2 signed 16-bit little-endian, 3 A-law, 6 signed 16-bit big-endian.
- R7: Codes 4, 5 and 7 raise the format error output. An accepted format write with such a code drops the DMA request.
- R8: Register 9 stores the byte with bit 5 cleared. If bit 6 is clear, bit 0 set raises the DMA request when the current format is valid, and bit 0 clear releases it. If bit 6 is set, the request is unchanged.
- R9: A write to direct location 2 clears the interrupt flag and line, and clears bits 6:4 of register 24.
- R10: A write to register 24 that takes bit 4 from 1 to 0 lowers the interrupt line and flag.
- R11: Writes to registers 11, 18, 20 and 28 are ignored, and these registers read zero. In register 12 only bit 6 is writable.
- R12: A play_done pulse sets register 24 bit 4 and raises the interrupt. It wins over a clear in the same cycle.
- R13: After reset all registers, the pointer and the interrupt read zero, the DMA request is inactive and extended mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the direct location on addr |
| addr | input | 2 | Direct location select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the location on addr (combinational) |
| play_done | input | 1 | Playback-done event pulse |
| dma_req | output | 1 | DMA request level |
| irq | output | 1 | Interrupt line |
| fmt_xtal | output | 1 | Decoded crystal select |
| fmt_rate | output | 3 | Decoded rate index |
| fmt_stereo | output | 1 | Decoded stereo flag |
| fmt_code | output | 3 | Decoded sample-format code |
| fmt_err | output | 1 | Unsupported or reserved format code |

## Verification
Two things can land on the interrupt state in the same clock: a play_done event that raises it, and a host write that clears it. The host write is either to the status location or to register 24 with bit 4 falling. The bench drives play_done together with each kind of clearing write. It expects the interrupt high and bit 4 of register 24 set afterwards. A behavioural reference model is compared on every clock, so any cycle where the clear overrides the event shows up as a miscompare.

// File: rtl/codec_idx_regs.sv
module codec_idx_regs #(
  parameter int NREG = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       play_done,
  output logic       dma_req,
  output logic       irq,
  output logic       fmt_xtal,
  output logic [2:0] fmt_rate,
  output logic       fmt_stereo,
  output logic [2:0] fmt_code,
  output logic       fmt_err
);
  localparam int IW = $clog2(NREG);
  localparam logic [IW-1:0] IX_FMT = IW'(8);
  localparam logic [IW-1:0] IX_CFG = IW'(9);
  localparam logic [IW-1:0] IX_ERR = IW'(11);
  localparam logic [IW-1:0] IX_MOD = IW'(12);
  localparam logic [IW-1:0] IX_RS0 = IW'(18);
  localparam logic [IW-1:0] IX_RS1 = IW'(20);
  localparam logic [IW-1:0] IX_ALT = IW'(24);
  localparam logic [IW-1:0] IX_RS2 = IW'(28);

  logic [7:0]    rf [NREG];
  logic [7:0]    idx_q;
  logic          int_q;
  logic          dma_q;
  logic          ext;
  logic          mce;
  logic          pmce;
  logic [IW-1:0] ia;
  logic [7:0]    fmt_part;

  assign ext      = rf[IX_MOD][6];
  assign mce      = idx_q[6];
  assign pmce     = rf[IX_ALT][3];
  assign ia       = ext ? idx_q[IW-1:0] : {1'b0, idx_q[IW-2:0]};
  assign fmt_part = {wdata[7:4], rf[IX_FMT][3:0]};

  function automatic logic bad_fmt(input logic [7:0] f, input logic m2);
    logic [2:0] c;
    c = m2 ? f[7:5] : {1'b0, f[6:5]};
    return (c == 3'd4) || (c == 3'd5) || (c == 3'd7);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      idx_q <= '0;
      int_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (addr)
          2'd0: idx_q <= {1'b0, wdata[6:0]};
          2'd1: begin
            case (ia)
              IX_FMT: begin
                if (mce) begin
                  rf[IX_FMT] <= wdata;
                  dma_q      <= rf[IX_CFG][0] & ~bad_fmt(wdata, ext);
                end else if (pmce) begin
                  rf[IX_FMT] <= fmt_part;
                  dma_q      <= rf[IX_CFG][0] & ~bad_fmt(fmt_part, ext);
                end
              end
              IX_CFG: begin
                rf[IX_CFG] <= wdata & 8'hDF;
                if (!wdata[6]) dma_q <= wdata[0] & ~bad_fmt(rf[IX_FMT], ext);
              end
              IX_ERR, IX_RS0, IX_RS1, IX_RS2: ;
              IX_MOD: rf[IX_MOD] <= {1'b0, wdata[6], 6'b0};
              IX_ALT: begin
                rf[IX_ALT] <= wdata;
                if (rf[IX_ALT][4] && !wdata[4]) int_q <= 1'b0;
              end
              default: rf[ia] <= wdata;
            endcase
          end
          2'd2: begin
            int_q           <= 1'b0;
            rf[IX_ALT][6:4] <= 3'b000;
          end
          default: ;
        endcase
      end
      if (play_done) begin
        int_q         <= 1'b1;
        rf[IX_ALT][4] <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = idx_q;
      2'd1:    rdata = rf[ia];
      2'd2:    rdata = {7'b0, int_q};
      default: rdata = 8'h00;
    endcase
  end

  assign dma_req    = dma_q;
  assign irq        = int_q;
  assign fmt_xtal   = rf[IX_FMT][0];
  assign fmt_rate   = rf[IX_FMT][3:1];
  assign fmt_stereo = rf[IX_FMT][4];
  assign fmt_code   = ext ? rf[IX_FMT][7:5] : {1'b0, rf[IX_FMT][6:5]};
  assign fmt_err    = bad_fmt(rf[IX_FMT], ext);
endmodule

// File: rtl/codec_idx_regs_chk.sv
module codec_idx_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       play_done,
  input logic       dma_req,
  input logic       irq,
  input logic       fmt_xtal,
  input logic [2:0] fmt_rate,
  input logic       fmt_stereo,
  input logic [2:0] fmt_code,
  input logic       fmt_err,
  input logic [4:0] ia,
  input logic       mce,
  input logic       pmce
);
  logic fmt_wr;
  assign fmt_wr = wr_en && addr == 2'd1 && ia == 5'd8;

  p_fmt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_wr && !mce && !pmce |=> $stable({fmt_xtal, fmt_rate, fmt_stereo, fmt_code}));

  p_bad_fmt_nodma_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_wr && mce |=> !(fmt_err && dma_req));

  p_cfg_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd1 && ia == 5'd9 && !wdata[6] && !wdata[0] |=> !dma_req);

  p_status_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd2 && !play_done |=> !irq);

  p_event_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    play_done |=> irq);

  p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(play_done));
endmodule

bind codec_idx_regs codec_idx_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .play_done(play_done), .dma_req(dma_req), .irq(irq),
  .fmt_xtal(fmt_xtal), .fmt_rate(fmt_rate), .fmt_stereo(fmt_stereo),
  .fmt_code(fmt_code), .fmt_err(fmt_err), .ia(ia), .mce(mce), .pmce(pmce)
);

// File: tb/codec_idx_regs_tb.sv
`timescale 1ns/1ps
module codec_idx_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic       play_done = 1'b0;
  logic [7:0] rdata;
  logic       dma_req, irq, fmt_xtal, fmt_stereo, fmt_err;
  logic [2:0] fmt_rate, fmt_code;

  int vecs = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  codec_idx_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .play_done(play_done), .dma_req(dma_req), .irq(irq),
    .fmt_xtal(fmt_xtal), .fmt_rate(fmt_rate), .fmt_stereo(fmt_stereo),
    .fmt_code(fmt_code), .fmt_err(fmt_err)
  );

  int m_rf [32];
  int m_idx, m_int, m_dma;

  function automatic int m_ext();
    return (m_rf[12] >> 6) & 1;
  endfunction
  function automatic int m_code(int f);
    return m_ext() ? (f >> 5) & 7 : (f >> 5) & 3;
  endfunction
  function automatic int m_bad(int f);
    int c;
    c = m_code(f);
    return (c == 4 || c == 5 || c == 7) ? 1 : 0;
  endfunction
  function automatic int m_rd(int a);
    int i;
    i = m_ext() ? (m_idx & 31) : (m_idx & 15);
    case (a)
      0: return m_idx;
      1: return m_rf[i];
      2: return m_int;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_rf[k]) m_rf[k] = 0;
      m_idx = 0; m_int = 0; m_dma = 0;
    end else begin
      int i, d, nf;
      d = int'(wdata);
      i = m_ext() ? (m_idx & 31) : (m_idx & 15);
      if (wr_en) begin
        if (addr == 0) m_idx = d % 128;
        else if (addr == 2) begin
          m_int = 0;
          m_rf[24] = m_rf[24] & ~112;
        end else if (addr == 1) begin
          if (i == 8) begin
            nf = -1;
            if ((m_idx / 64) % 2 == 1) nf = d;
            else if ((m_rf[24] / 8) % 2 == 1) nf = (d / 16) * 16 + m_rf[8] % 16;
            if (nf >= 0) begin
              m_rf[8] = nf;
              m_dma = (m_rf[9] % 2 == 1 && m_bad(nf) == 0) ? 1 : 0;
            end
          end else if (i == 9) begin
            m_rf[9] = d & ~32;
            if ((d / 64) % 2 == 0) m_dma = (d % 2 == 1 && m_bad(m_rf[8]) == 0) ? 1 : 0;
          end else if (i == 11 || i == 18 || i == 20 || i == 28) begin
          end else if (i == 12) m_rf[12] = d & 64;
          else if (i == 24) begin
            if ((m_rf[24] / 16) % 2 == 1 && (d / 16) % 2 == 0) m_int = 0;
            m_rf[24] = d;
          end else m_rf[i] = d;
        end
      end
      if (play_done) begin
        m_int = 1;
        m_rf[24] = m_rf[24] | 16;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    int f;
    f = m_rf[8];
    chk("R6/R7/R8/R12 model outputs",
        {dma_req, irq, fmt_xtal, fmt_rate, fmt_stereo, fmt_code, fmt_err},
        {m_dma[0], m_int[0], f[0], f[3:1], f[4], m_code(f) % 8 == 0 ? 3'd0 : 3'(m_code(f)), m_bad(f) == 1});
    chk("R1/R2/R11 model read", int'(rdata), m_rd(int'(addr)));
  end

  task automatic cyc(bit w, int a, int d, bit pd);
    wr_en = w; addr = 2'(a); wdata = 8'(d); play_done = pd;
    @(posedge clk); #1;
    wr_en = 1'b0; play_done = 1'b0;
  endtask
  task automatic wr(int a, int d);
    cyc(1'b1, a, d, 1'b0);
  endtask
  task automatic wind(int ix, int d);
    wr(0, ix);
    wr(1, d);
  endtask
  task automatic rd(int a, int exp, string req);
    addr = 2'(a);
    #1;
    chk(req, int'(rdata), exp);
  endtask
  task automatic rind(int ix, int exp, string req);
    wr(0, ix);
    rd(1, exp, req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R13 dma_req after reset", dma_req, 0);
    chk("R13 irq after reset", irq, 0);
    rd(0, 8'h00, "R13 pointer after reset");
    rd(2, 8'h00, "R13 status after reset");
    rind(12, 8'h00, "R13 extended mode off after reset");

    wr(0, 8'hC5);
    rd(0, 8'h45, "R1 pointer bit 7 forced low");

    wind(8'h13, 8'hAA);
    rind(8'h03, 8'hAA, "R2 4-bit index aliases 0x13 to 3");
    wind(8'h0C, 8'hFF);
    rd(1, 8'h40, "R11 only mode bit 6 writable");
    rind(8'h13, 8'h00, "R2 5-bit index reaches 19");
    rind(8'h03, 8'hAA, "R2 register 3 intact");
    wind(8'h0B, 8'h55);
    rd(1, 8'h00, "R11 error status ignores write");
    wind(8'h14, 8'h77);
    rd(1, 8'h00, "R11 reserved 20 ignores write");
    wind(8'h1C, 8'h33);
    rd(1, 8'h00, "R11 reserved 28 ignores write");

    wind(8'h48, 8'h5B);
    chk("R3 full format write", {fmt_xtal, fmt_rate, fmt_stereo, fmt_code}, {1'b1, 3'd5, 1'b1, 3'd2});
    chk("R6 code 2 valid", fmt_err, 0);
    wind(8'h49, 8'h21);
    rd(1, 8'h01, "R8 config bit 5 reads zero");
    chk("R8 enable raises request", dma_req, 1);
    wind(8'h48, 8'h80);
    chk("R7 code 4 error", fmt_err, 1);
    chk("R7 code 4 drops request", dma_req, 0);
    wr(1, 8'hA0);
    chk("R7 code 5 error", fmt_err, 1);
    wr(1, 8'hE0);
    chk("R7 code 7 error", fmt_err, 1);
    wr(1, 8'hC0);
    chk("R6 code 6 big-endian valid", {fmt_code, fmt_err}, {3'd6, 1'b0});
    chk("R7 valid format restores request", dma_req, 1);

    wind(8'h4C, 8'h00);
    chk("R6 code masked without extended mode", fmt_code, 2);

    wind(8'h08, 8'h11);
    rd(1, 8'hC0, "R5 ungated format write discarded");
    wind(8'h0C, 8'h40);
    wind(8'h18, 8'h08);
    wind(8'h08, 8'h3F);
    rd(1, 8'h30, "R4 partial change keeps low nibble");
    chk("R6 code 1 mu-law", fmt_code, 1);

    wind(8'h09, 8'h40);
    chk("R8 PIO select leaves request", dma_req, 1);
    wr(1, 8'h00);
    chk("R8 disable releases request", dma_req, 0);

    cyc(1'b0, 0, 0, 1'b1);
    chk("R12 event raises irq", irq, 1);
    rind(8'h18, 8'h18, "R12 event sets pending bit 4");
    wr(1, 8'h78);
    wr(2, 8'h00);
    chk("R9 status write clears irq", irq, 0);
    rind(8'h18, 8'h08, "R9 pending bits 6:4 cleared");

    cyc(1'b0, 0, 0, 1'b1);
    wr(0, 8'h18);
    wr(1, 8'h08);
    chk("R10 pending 1->0 lowers irq", irq, 0);

    cyc(1'b0, 0, 0, 1'b1);
    cyc(1'b1, 2, 0, 1'b1);
    chk("R12 event wins over status clear", irq, 1);
    cyc(1'b1, 1, 8'h08, 1'b1);
    chk("R12 event wins over pending clear", irq, 1);
    rd(1, 8'h18, "R12 pending bit kept set");

    wind(8'h05, 8'h9C);
    wind(8'h1F, 8'h42);
    rind(8'h05, 8'h9C, "R2 plain register 5");
    rind(8'h1F, 8'h42, "R2 plain register 31");

    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule